// File: doc/BRIEF.md
# Paired-Write Buffer Address Load Port

This block is one byte-wide host register port inside a small peripheral register file. It has two jobs. On the read side it returns one of two bytes. The first is a fixed identification byte that holds a chip-type code and a revision number. The second is a readback of a staged address byte. A control bit from the neighbouring interrupt/control register picks between them.

On the write side the port builds a 16-bit buffer address out of two byte writes in a row. The low byte comes first and is held in a staging register. The high byte comes second, and both bytes are then moved into the buffer counter as one operation. A second control bit must be set for this loading to work. Any other host access that falls between the two writes cancels the pair, so the next write is again taken as a low byte. After a load, the counter advances by one on every pipe data transfer strobe.

Top module: `pipe_addr_port`

## Requirements
- R1: After reset the buffer counter is 0x0000, the staging register reads 0x22, and with strap low and address-valid low a port read returns 0x40.
- R2: With address-valid low, a read of the port (offset 7) returns the chip type in bits 7..4 and the revision (0) in bits 3..0. The chip type is 0100 when the strap is low and 0010 when the strap is high.
- R3: With address-valid high, a read of the port returns the staging register.
- R4: With pipe-enable high, the second write of a pair pulses the load output in that same cycle, with value {high byte, staged low byte}. The counter holds that value from the next cycle on.
- R5: With pipe-enable high, the first write of a pair stores its byte in the staging register and does not load the counter.
- R6: Any host read (including a read of the port itself), or any write to another offset, made while a low byte is pending cancels the pair. The next port write is then a low byte. Cycles with no host access do not cancel the pair.
- R7: Port writes made while pipe-enable is low leave the staging register and the counter unchanged. Pipe-enable low also cancels a pending pair.
- R8: With no load in a cycle, a transfer strobe increments the counter by one, wrapping from 0xFFFF to 0x0000.
- R9: A load and a transfer strobe in the same cycle give the loaded value, not an incremented one.
- R10: Reads of any offset other than 7, and cycles with no read, drive 0x00 on the read data output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | ADDR_W | Register offset of the host access |
| host_wdata | input | 8 | Host write data |
| host_rd | input | 1 | Read strobe, one cycle per access |
| host_wr | input | 1 | Write strobe, one cycle per access |
| ctl_addr_valid | input | 1 | Read selector: 1 returns the staging register |
| ctl_pipe_en | input | 1 | Enables address loading through the port |
| strap_alt_type | input | 1 | Selects the alternate chip-type code |
| xfer_strobe | input | 1 | Pipe data transfer, increments the counter |
| rd_data | output | 8 | Read data from this port |
| cnt_load | output | 1 | Counter load pulse, high in the cycle of the second write |
| cnt_load_val | output | CNT_W | Value loaded into the counter |
| buf_count | output | CNT_W | Buffer counter |

## Verification
A phase flag that is stuck or cleared at the wrong time shows up at the ports within one write. A missed load pulse, a load on the first write, or a counter that ends up holding a stale low byte appears on the very next port write after the event that should have cleared the flag. A corrupt staging register appears on the next port read with address-valid high. A counter fault appears one cycle after the load or strobe that caused it. The stimulus therefore places every kind of interfering access directly between the two writes of a pair, then completes the pair and compares the counter.

// File: rtl/pipe_port_pkg.sv
package pipe_port_pkg;

  typedef enum logic [3:0] {
    CT_PRIMARY = 4'b0100,
    CT_ALT     = 4'b0010
  } chip_type_e;

  // identification byte: type code high nibble, revision low nibble
  function automatic logic [7:0] id_byte(input logic alt, input logic [3:0] rev);
    chip_type_e ct;
    ct = alt ? CT_ALT : CT_PRIMARY;
    return {ct, rev};
  endfunction

  // counter step with natural wrap
  function automatic logic [15:0] count_step(input logic [15:0] cur);
    return cur + 16'd1;
  endfunction

endpackage

// File: rtl/ppa_pair_seq.sv
module ppa_pair_seq #(
  parameter logic [7:0] TEMP_RST = 8'h22
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_sel,
  input  logic        host_rd,
  input  logic        host_wr,
  input  logic [7:0]  host_wdata,
  input  logic        pipe_en,
  output logic [7:0]  temp_q,
  output logic        load,
  output logic [15:0] load_val
);

  logic phase_q;
  logic port_wr, wr_accept, low_cap, hi_done, foreign_acc;

  assign port_wr     = host_wr & host_sel;
  assign wr_accept   = port_wr & pipe_en;
  assign low_cap     = wr_accept & ~phase_q;
  assign hi_done     = wr_accept & phase_q;
  assign foreign_acc = host_rd | (host_wr & ~host_sel);

  assign load     = hi_done;
  assign load_val = {host_wdata, temp_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      temp_q  <= TEMP_RST;
    end else begin
      if (low_cap) temp_q <= host_wdata;
      if (!pipe_en || hi_done || foreign_acc) phase_q <= 1'b0;
      else if (low_cap)                       phase_q <= 1'b1;
    end
  end

  // R5
  low_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    low_cap |=> (phase_q && temp_q == $past(host_wdata)));
  // R4
  pair_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !phase_q);
  // R6
  abort_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q && foreign_acc) |=> !phase_q);
  // R7
  ignored_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && !pipe_en) |=> ($stable(temp_q) && !phase_q));

endmodule

// File: rtl/ppa_read_mux.sv
module ppa_read_mux
  import pipe_port_pkg::*;
#(
  parameter logic [3:0] REV_NUM = 4'h0
) (
  input  logic       host_sel,
  input  logic       host_rd,
  input  logic       addr_valid,
  input  logic       strap_alt,
  input  logic [7:0] temp_q,
  output logic [7:0] rd_data
);

  logic [7:0] id_val;
  assign id_val = id_byte(strap_alt, REV_NUM);

  always_comb begin
    rd_data = 8'h00;
    if (host_rd && host_sel) rd_data = addr_valid ? temp_q : id_val;
  end

  // R10
  idle_zero_chk: assert final (host_rd || rd_data == 8'h00);

endmodule

// File: rtl/ppa_buf_counter.sv
module ppa_buf_counter
  import pipe_port_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             step,
  output logic [CNT_W-1:0] count
);

  always_ff @(posedge clk) begin
    if (!rst_n)    count <= '0;
    else if (load) count <= load_val;
    else if (step) count <= count_step(count);
  end

  // R8
  step_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && step) |=> count == $past(count) + 1'b1);
  // R9
  load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> count == $past(load_val));

endmodule

// File: rtl/pipe_addr_port.sv
module pipe_addr_port #(
  parameter int             ADDR_W   = 4,
  parameter logic [ADDR_W-1:0] PORT_OFS = 7,
  parameter logic [3:0]     REV_NUM  = 4'h0,
  parameter logic [7:0]     TEMP_RST = 8'h22,
  parameter int             CNT_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [7:0]        host_wdata,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic              ctl_addr_valid,
  input  logic              ctl_pipe_en,
  input  logic              strap_alt_type,
  input  logic              xfer_strobe,
  output logic [7:0]        rd_data,
  output logic              cnt_load,
  output logic [CNT_W-1:0]  cnt_load_val,
  output logic [CNT_W-1:0]  buf_count
);

  logic       host_sel;
  logic [7:0] temp_q;

  assign host_sel = (host_addr == PORT_OFS);

  ppa_pair_seq #(.TEMP_RST(TEMP_RST)) u_seq (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_rd(host_rd),
    .host_wr(host_wr), .host_wdata(host_wdata), .pipe_en(ctl_pipe_en),
    .temp_q(temp_q), .load(cnt_load), .load_val(cnt_load_val)
  );

  ppa_read_mux #(.REV_NUM(REV_NUM)) u_mux (
    .host_sel(host_sel), .host_rd(host_rd), .addr_valid(ctl_addr_valid),
    .strap_alt(strap_alt_type), .temp_q(temp_q), .rd_data(rd_data)
  );

  ppa_buf_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(cnt_load_val),
    .step(xfer_strobe), .count(buf_count)
  );

  // R4
  single_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_load |=> !cnt_load);

endmodule

// File: tb/pipe_addr_port_tb.sv
module pipe_addr_port_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0]  host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic host_rd = 0, host_wr = 0, av = 0, pe = 0, strap = 0, strobe = 0;
  logic [7:0]  rd_data;
  logic        cnt_load;
  logic [15:0] cnt_load_val, buf_count;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pipe_addr_port dut_i (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rd(host_rd), .host_wr(host_wr), .ctl_addr_valid(av),
    .ctl_pipe_en(pe), .strap_alt_type(strap), .xfer_strobe(strobe),
    .rd_data(rd_data), .cnt_load(cnt_load), .cnt_load_val(cnt_load_val),
    .buf_count(buf_count)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // fields: op(0 idle,1 wr,2 rd), addr, data, av, pe, strobe, exp_rd, exp_ld, exp_cnt
  localparam int NV = 26;
  localparam logic [41:0] VEC [0:NV-1] = '{
    {2'd2,4'h7,8'h00,1'b0,1'b0,1'b0,8'h40,1'b0,16'h0000}, // R1 R2 id
    {2'd2,4'h7,8'h00,1'b1,1'b0,1'b0,8'h22,1'b0,16'h0000}, // R1 R3
    {2'd1,4'h7,8'h55,1'b0,1'b0,1'b0,8'h00,1'b0,16'h0000}, // R7 ignored
    {2'd2,4'h7,8'h00,1'b1,1'b0,1'b0,8'h22,1'b0,16'h0000}, // R7 temp kept
    {2'd1,4'h7,8'h34,1'b0,1'b1,1'b0,8'h00,1'b0,16'h0000}, // R5 low
    {2'd1,4'h7,8'h12,1'b0,1'b1,1'b0,8'h00,1'b1,16'h1234}, // R4 high
    {2'd2,4'h7,8'h00,1'b1,1'b1,1'b0,8'h34,1'b0,16'h1234}, // R3
    {2'd0,4'h0,8'h00,1'b0,1'b1,1'b1,8'h00,1'b0,16'h1235}, // R8
    {2'd1,4'h7,8'hAA,1'b0,1'b1,1'b0,8'h00,1'b0,16'h1235}, // R5
    {2'd2,4'h3,8'h00,1'b0,1'b1,1'b0,8'h00,1'b0,16'h1235}, // R6 R10 other read
    {2'd1,4'h7,8'hBB,1'b0,1'b1,1'b0,8'h00,1'b0,16'h1235}, // R6 low again
    {2'd1,4'h7,8'h0C,1'b0,1'b1,1'b0,8'h00,1'b1,16'h0CBB}, // R4
    {2'd1,4'h7,8'h01,1'b0,1'b1,1'b0,8'h00,1'b0,16'h0CBB}, // R5
    {2'd1,4'h5,8'h99,1'b0,1'b1,1'b0,8'h00,1'b0,16'h0CBB}, // R6 other write
    {2'd1,4'h7,8'hFF,1'b0,1'b1,1'b0,8'h00,1'b0,16'h0CBB}, // R6 low again
    {2'd2,4'h7,8'h00,1'b1,1'b1,1'b0,8'hFF,1'b0,16'h0CBB}, // R6 port read aborts
    {2'd1,4'h7,8'hFF,1'b0,1'b1,1'b0,8'h00,1'b0,16'h0CBB}, // R6 low again
    {2'd1,4'h7,8'hFF,1'b0,1'b1,1'b1,8'h00,1'b1,16'hFFFF}, // R9 load wins
    {2'd0,4'h0,8'h00,1'b0,1'b1,1'b1,8'h00,1'b0,16'h0000}, // R8 wrap
    {2'd1,4'h7,8'h10,1'b0,1'b1,1'b0,8'h00,1'b0,16'h0000}, // R5
    {2'd0,4'h0,8'h00,1'b0,1'b0,1'b0,8'h00,1'b0,16'h0000}, // R7 pe low aborts
    {2'd1,4'h7,8'h20,1'b0,1'b1,1'b0,8'h00,1'b0,16'h0000}, // R7 low again
    {2'd1,4'h7,8'h30,1'b0,1'b1,1'b0,8'h00,1'b1,16'h3020}, // R4
    {2'd1,4'h7,8'h44,1'b0,1'b1,1'b0,8'h00,1'b0,16'h3020}, // R5
    {2'd0,4'h0,8'h00,1'b0,1'b1,1'b0,8'h00,1'b0,16'h3020}, // R6 idle keeps pair
    {2'd1,4'h7,8'h55,1'b0,1'b1,1'b0,8'h00,1'b1,16'h5544}  // R4
  };

  task automatic idle_inputs();
    host_rd = 0; host_wr = 0; strobe = 0; host_addr = '0; host_wdata = '0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    check("R1 count", buf_count, 16'h0000);
    for (int i = 0; i < NV; i++) begin
      logic [41:0] v;
      v = VEC[i];
      @(negedge clk);
      host_rd = (v[41:40] == 2'd2); host_wr = (v[41:40] == 2'd1);
      host_addr = v[39:36]; host_wdata = v[35:28];
      av = v[27]; pe = v[26]; strobe = v[25];
      #1;
      check($sformatf("R2/R3/R10 rd vec%0d", i), {8'h00, rd_data}, {8'h00, v[24:17]});
      check($sformatf("R4/R5 load vec%0d", i), {15'd0, cnt_load}, {15'd0, v[16]});
      @(posedge clk); #1;
      check($sformatf("R4/R8/R9 count vec%0d", i), buf_count, v[15:0]);
      idle_inputs();
    end
    // R2 alternate strap
    @(negedge clk); strap = 1; av = 0; host_rd = 1; host_addr = 4'h7; #1;
    check("R2 alt type", {8'h00, rd_data}, 16'h0020);
    idle_inputs(); strap = 0;
    // R1 reset mid-run
    @(negedge clk); rst_n = 0;
    @(posedge clk); #1; rst_n = 1;
    check("R1 count after reset", buf_count, 16'h0000);
    @(negedge clk); av = 1; host_rd = 1; host_addr = 4'h7; #1;
    check("R1 temp after reset", {8'h00, rd_data}, 16'h0022);
    av = 0; #1;
    check("R1 id after reset", {8'h00, rd_data}, 16'h0040);
    idle_inputs();
    // R10 no read drives zero
    #1; check("R10 idle rd", {8'h00, rd_data}, 16'h0000);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule